// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is a master-only serial port for devices that take a command word and then return a response word over separate data lines. The host hands it one command at a time through a valid/ready handshake, together with the command length and the expected response length. The block then pulls its active-low select low and runs the serial clock. It shifts the command out, most significant bit first, and then clocks the response in, most significant bit first. When the last response bit has been captured, it returns the word with a one-cycle strobe. Data moves in one direction at a time. While the response is being read, the output line is held low.

The serial clock idles low. Its half period is a number of system clocks set by the `cfg_half` input, so the full clock ratio is always even. Output data changes on the falling edge of the serial clock, and input data is captured on the rising edge. If another command is waiting when a response completes, the select stays low. The next command then starts on the same falling edge, and the serial clock runs without a gap. Otherwise the select rises half a serial period after the last rising edge. `cfg_half` must be at least 1 and must only be changed while the port is idle. Both lengths must lie in 4..32.

Top module: `mw_master`

## Requirements
- R1: After reset, and whenever the port is idle, `mw_cs_n` is 1, `mw_sclk` is 0, `mw_dout` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: `mw_cs_n` goes low in the cycle a command is accepted and stays low through the last response bit. When no command is waiting, it rises exactly `cfg_half` system cycles after the final rising edge of `mw_sclk`.
- R3: If `cmd_valid` is high at the falling edge that ends a response, that command is accepted on that edge. `mw_cs_n` does not rise between the two transfers, and the `mw_sclk` period stays at 2·`cfg_half` across the boundary.
- R4: `mw_dout` changes only when `mw_sclk` falls or `mw_cs_n` falls. `mw_din` is captured on the system edge where `mw_sclk` rises.
- R5: A command is taken from the low `cmd_len` bits of `cmd_word` (`cmd_len` in 4..32). It is sent most significant bit first, one bit per `mw_sclk` period.
- R6: The response phase begins at the falling edge after the last command bit and lasts `rsp_len` periods (4..32), with `mw_dout` held at 0. `rsp_word` carries the captured bits right-aligned, first bit most significant, with all bits above `rsp_len` at 0.
- R7: `mw_sclk` idles low. Its first rising edge comes `cfg_half` system cycles after a command is accepted from idle, and consecutive rising edges are 2·`cfg_half` cycles apart.
- R8: `rsp_valid` is a single-cycle pulse, one per transfer. It is high in the cycle in which `mw_sclk` has just risen for the last response bit.
- R9: `cmd_ready` is 0 while a transfer is in progress, except on the final falling edge. The level of `mw_din` during the command phase has no effect on `rsp_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | DIV_W | Serial half period in system cycles (at least 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_word | input | W | Command bits, right-aligned |
| cmd_len | input | LW | Command length in bits, 4..W |
| rsp_len | input | LW | Response length in bits, 4..W |
| rsp_valid | output | 1 | One-cycle strobe: response complete |
| rsp_word | output | W | Captured response, right-aligned |
| mw_cs_n | output | 1 | Active-low device select |
| mw_sclk | output | 1 | Serial clock, idles low |
| mw_dout | output | 1 | Serial data to the device |
| mw_din | input | 1 | Serial data from the device |

## Verification
The bench models the device. It drives `mw_din` high throughout every command phase and presents response bits only on falling edges. A design that sampled on the wrong edge, or that picked up input during the command, would return a corrupted word. Commands are issued back to back to check that the select never rises between them. A design that released the select, or that restarted the clock divider at the boundary, would show an extra select pulse or a stretched clock period. The 4-bit and 32-bit lengths are exercised at the smallest and at larger half periods. These runs expose off-by-one errors in the bit counter, which would show up as a shifted word or as a select that rises a cycle early or late.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RSP  = 2'd2
  } mw_state_e;
endpackage

// File: rtl/mw_baud.sv
module mw_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == half - DIV_W'(1));
  assign tick   = run & at_end;

  always_comb begin
    if (!run || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/mw_shreg.sv
module mw_shreg #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic [LW-1:0] load_len,
  input  logic          adv_out,
  input  logic          clr,
  input  logic          adv_in,
  input  logic          sin,
  output logic          sout,
  output logic [W-1:0]  word_in
);
  logic [W-1:0]  out_q, out_d, in_q, in_d;
  logic [LW-1:0] sh_amt;

  assign sh_amt  = LW'(W) - load_len;
  assign sout    = out_q[W-1];
  assign word_in = in_q;

  always_comb begin
    out_d = out_q;
    if (load)         out_d = load_word << sh_amt;
    else if (clr)     out_d = '0;
    else if (adv_out) out_d = {out_q[W-2:0], 1'b0};
  end

  always_comb begin
    in_d = in_q;
    if (clr)         in_d = '0;
    else if (adv_in) in_d = {in_q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      out_q <= out_d;
      in_q  <= in_d;
    end
  end
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIV_W = 8,
  parameter int LW    = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [W-1:0]     cmd_word,
  input  logic [LW-1:0]    cmd_len,
  input  logic [LW-1:0]    rsp_len,
  output logic             rsp_valid,
  output logic [W-1:0]     rsp_word,
  output logic             mw_cs_n,
  output logic             mw_sclk,
  output logic             mw_dout,
  input  logic             mw_din
);
  logic [1:0]    rst_sync_q;
  logic          rs_n;
  mw_state_e     state_q, state_d;
  logic          sclk_q, sclk_d, cs_n_q, cs_n_d, vld_q, vld_d;
  logic [LW-1:0] bit_q, bit_d, rlen_q, rlen_d;
  logic          tick, rise, fall, last_bit, accept, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rs_n = rst_sync_q[1];

  assign run      = (state_q != ST_IDLE);
  assign rise     = tick & ~sclk_q;
  assign fall     = tick & sclk_q;
  assign last_bit = (bit_q == '0);

  mw_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rs_n), .run(run), .half(cfg_half), .tick(tick)
  );

  assign cmd_ready = (state_q == ST_IDLE) | ((state_q == ST_RSP) & fall & last_bit);
  assign accept    = cmd_valid & cmd_ready;

  mw_shreg #(.W(W), .LW(LW)) u_shreg (
    .clk(clk), .rst_n(rs_n),
    .load(accept), .load_word(cmd_word), .load_len(cmd_len),
    .adv_out((state_q == ST_CMD) & fall & ~last_bit),
    .clr((state_q == ST_CMD) & fall & last_bit),
    .adv_in((state_q == ST_RSP) & rise),
    .sin(mw_din), .sout(mw_dout), .word_in(rsp_word)
  );

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    bit_d   = bit_q;
    rlen_d  = rlen_q;
    vld_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_CMD;
          cs_n_d  = 1'b0;
          bit_d   = cmd_len - LW'(1);
          rlen_d  = rsp_len;
        end
      end
      ST_CMD: begin
        if (rise) sclk_d = 1'b1;
        if (fall) begin
          sclk_d = 1'b0;
          if (last_bit) begin
            state_d = ST_RSP;
            bit_d   = rlen_q - LW'(1);
          end else begin
            bit_d = bit_q - LW'(1);
          end
        end
      end
      ST_RSP: begin
        if (rise) begin
          sclk_d = 1'b1;
          vld_d  = last_bit;
        end
        if (fall) begin
          sclk_d = 1'b0;
          if (!last_bit) begin
            bit_d = bit_q - LW'(1);
          end else if (accept) begin
            state_d = ST_CMD;
            bit_d   = cmd_len - LW'(1);
            rlen_d  = rsp_len;
          end else begin
            state_d = ST_IDLE;
            cs_n_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      bit_q   <= '0;
      rlen_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      bit_q   <= bit_d;
      rlen_q  <= rlen_d;
      vld_q   <= vld_d;
    end
  end

  assign mw_sclk   = sclk_q;
  assign mw_cs_n   = cs_n_q;
  assign rsp_valid = vld_q;

  p_cs_low_busy_r2: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q != ST_IDLE) |-> !mw_cs_n);
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rs_n)
    mw_cs_n |-> !mw_sclk);
  p_dout_edge_r4: assert property (@(posedge clk) disable iff (!rs_n)
    !$stable(mw_dout) |-> ($fell(mw_sclk) || $fell(mw_cs_n)));
  p_rsp_quiet_r6: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q == ST_RSP) |-> !mw_dout);
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rs_n)
    rsp_valid |=> !rsp_valid);
  p_vld_edge_r8: assert property (@(posedge clk) disable iff (!rs_n)
    rsp_valid |-> $rose(mw_sclk));
endmodule

// File: tb/sim_mw_master.sv
module sim_mw_master;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] cmd;
    int          clen;
    logic [31:0] rsp;
    int          rlen;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_half;
  logic        cmd_valid, cmd_ready, rsp_valid;
  logic [31:0] cmd_word, rsp_word;
  logic [5:0]  cmd_len, rsp_len;
  logic        mw_cs_n, mw_sclk, mw_dout, mw_din;

  item_t       dev_q[$];
  logic [31:0] rsp_q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, n_rsp = 0, n_sent = 0;
  int cs_fall = 0, prev_rise = 0, cs_rises = 0;
  bit first_rise = 1'b0, started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  mw_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_len(cmd_len), .rsp_len(rsp_len), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .mw_cs_n(mw_cs_n), .mw_sclk(mw_sclk),
    .mw_dout(mw_dout), .mw_din(mw_din)
  );

  function automatic logic [31:0] msk(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: queue expectations, then offer the command until it is taken
  task automatic send(logic [31:0] c, int cl, logic [31:0] r, int rl);
    item_t it;
    bit taken;
    it = '{c, cl, r, rl};
    dev_q.push_back(it);
    rsp_q.push_back(r & msk(rl));
    n_sent++;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = c;
    cmd_len   = 6'(cl);
    rsp_len   = 6'(rl);
    taken = 1'b0;
    while (!taken) begin
      if (cmd_ready) begin
        @(posedge clk);
        taken = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic drop();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (rsp_q.size() != 0 || !mw_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Device model: reads the command on rising edges, drives response on falling edges
  initial begin : device
    item_t it;
    logic [31:0] got;
    forever begin
      while (dev_q.size() == 0) @(negedge clk);
      it = dev_q.pop_front();
      mw_din = 1'b1;  // noise during command phase (R9)
      got = '0;
      for (int i = 0; i < it.clen; i++) begin
        @(posedge mw_sclk);
        got = {got[30:0], mw_dout};
        if (mw_cs_n) chk(1'b0, "R2 select low during command", 32'(mw_cs_n), 32'd0);
      end
      chk(got == (it.cmd & msk(it.clen)), "R5 command bits", got, it.cmd & msk(it.clen));
      @(negedge mw_sclk);
      for (int i = 0; i < it.rlen; i++) begin
        mw_din = it.rsp[it.rlen - 1 - i];
        @(posedge mw_sclk);
        chk(!mw_dout, "R6 dout low in response", 32'(mw_dout), 32'd0);
        if (i < it.rlen - 1) @(negedge mw_sclk);
      end
    end
  end

  // Monitor: compare each response strobe with the scoreboard
  always @(negedge clk) begin
    if (started && rsp_valid) begin
      n_rsp++;
      if (rsp_q.size() == 0) chk(1'b0, "R8 unexpected strobe", 32'd1, 32'd0);
      else begin
        logic [31:0] e;
        e = rsp_q.pop_front();
        chk(rsp_word == e, "R6 R9 response word", rsp_word, e);
      end
    end
  end

  // Serial clock timing (R7) and select release (R2)
  always @(negedge mw_cs_n) begin
    cs_fall = cyc;
    first_rise = 1'b1;
  end
  always @(posedge mw_sclk) begin
    if (first_rise) chk(cyc - cs_fall == int'(cfg_half), "R7 first rise", 32'(cyc - cs_fall), 32'(cfg_half));
    else chk(cyc - prev_rise == 2 * int'(cfg_half), "R7 R3 period", 32'(cyc - prev_rise), 32'(2 * cfg_half));
    first_rise = 1'b0;
    prev_rise = cyc;
  end
  always @(posedge mw_cs_n) begin
    if (started) begin
      cs_rises++;
      chk(cyc - prev_rise == int'(cfg_half), "R2 select release", 32'(cyc - prev_rise), 32'(cfg_half));
    end
  end

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int rb;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; cmd_len = 6'd8; rsp_len = 6'd8;
    mw_din = 1'b0; cfg_half = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    started = 1'b1;
    chk(mw_cs_n == 1'b1, "R1 select idle", 32'(mw_cs_n), 32'd1);
    chk(mw_sclk == 1'b0, "R1 clock idle", 32'(mw_sclk), 32'd0);
    chk(mw_dout == 1'b0, "R1 dout idle", 32'(mw_dout), 32'd0);
    chk(cmd_ready == 1'b1, "R1 ready idle", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 no strobe", 32'(rsp_valid), 32'd0);

    // Single 8/8 transfer, half period 2
    send(32'h0000_00A5, 8, 32'h0000_003C, 8);
    drop();
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 ready low while busy", 32'(cmd_ready), 32'd0);
    wait_idle();
    chk(mw_cs_n && !mw_sclk && !mw_dout, "R1 idle after transfer", {mw_cs_n, mw_sclk, mw_dout}, 32'h4);

    // Full-width 32/32, fastest clock
    cfg_half = 8'd1;
    send(32'hDEAD_BEEF, 32, 32'h8123_4567, 32);
    drop();
    wait_idle();

    // Minimum 4/4, slower clock; upper command bits must be ignored
    cfg_half = 8'd3;
    send(32'hFFFF_FFF9, 4, 32'hFFFF_FFF6, 4);
    drop();
    wait_idle();

    // Mixed lengths
    cfg_half = 8'd2;
    send(32'h0001_2345, 17, 32'h0000_0A0A, 12);
    drop();
    wait_idle();

    // Back-to-back: select held, clock continuous (R3)
    rb = cs_rises;
    send(32'h0000_0055, 7, 32'h0000_01F1, 9);
    send(32'h0000_0C3A, 12, 32'h0000_0009, 4);
    send(32'h1234_5678, 32, 32'h0000_FFFF, 16);
    drop();
    wait_idle();
    chk(cs_rises - rb == 1, "R3 one select release for three commands", 32'(cs_rises - rb), 32'd1);

    chk(n_rsp == n_sent, "R8 one strobe per transfer", 32'(n_rsp), 32'(n_sent));
    chk(rsp_q.size() == 0, "R8 scoreboard drained", 32'(rsp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule